// File: doc/BRIEF.md
# Cascadable Four-Channel Down-Counter Group

This block holds four 32-bit down-counters that share one control word. The control word picks the time base and sets how the counters are wired together. The time base is either the system clock divided by 8, 16, 32 or 64, or the rising edges of an asynchronous real-time tick. The control word can also join neighbouring counters into longer chains. Inside a chain, the reload value of each member that has a more significant neighbour can be its base count or all ones. Each counter has a base-count register, a readable current count and an inhibit bit. Every counter emits a one-cycle terminal-count pulse each time it passes through zero.

A simple write/read register port programs and observes the group. Writes take effect at the clock edge where the write is presented. Reads are combinational from the selected address. Chaining is fixed to neighbours: a more significant counter steps only when the counter below it in the chain passes through zero. This lets two or more 32-bit counters act as one wider interval counter.

Top module: `cascade_timer_group`

## Requirements
- R1: Control bits [1:0] select the time base when bit 2 is clear: 00 divides the system clock by 8, 01 by 16, 10 by 32 and 11 by 64. The control word resets to zero, which gives divide by 8 with no chaining and no roll-over.
- R2: When control bit 2 is set, the time base is each rising edge of `rtc_tick_i`, counted after a two-stage synchroniser. Bits [1:0] then have no effect.
- R3: A control write that changes bits [2:0] restarts the prescaler from zero in that cycle. A control write that leaves them unchanged does not disturb the prescaler phase.
- R4: Control bits [5:3] pick the chaining: 000 none; 001 counters 0-1; 010 counters 1-2; 011 counters 0-1-2; 100 counters 2-3; 101 the pairs 0-1 and 2-3; 110 counters 1-2-3; 111 all four.
- R5: A counter that no chain feeds steps once per time-base tick. On a step it decrements, and at a step taken from zero it reloads.
- R6: A chained counter with a less significant neighbour steps only in the cycle where that neighbour passes through zero.
- R7: Control bits [8:6] are roll-over enables for counters 2, 1 and 0 (bit 8 for counter 2, bit 6 for counter 0). They apply only to chain members. A set bit makes that counter reload to 0xFFFF_FFFF instead of its base count.
- R8: Counter 3 always reloads with its base count.
- R9: A chain member whose more significant neighbour in the chain reads zero reloads with its base count, whatever its roll-over bit says.
- R10: A counter whose inhibit bit is set holds its count, emits no pulse and feeds no step upward. All four inhibit bits (address 9, bits [3:0]) are set after reset.
- R11: Base counts sit at addresses 1 to 4 and current counts at addresses 5 to 8, for counters 0 to 3. Writing a base while that counter is inhibited also loads its current count, which is readable in the next cycle. A base write to a running counter changes only the base.
- R12: `tc_pulse_o[k]` is high for exactly one cycle, the cycle after counter k steps from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rtc_tick_i | input | 1 | Asynchronous real-time tick, used when control bit 2 is set |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wr_addr | input | 4 | Write address (0 control, 1-4 base, 9 inhibit) |
| bus_wr_data | input | 32 | Write data |
| bus_rd_addr | input | 4 | Read address (0 control, 1-4 base, 5-8 count, 9 inhibit) |
| bus_rd_data | output | 32 | Read data, combinational from `bus_rd_addr` |
| tc_pulse_o | output | 4 | Terminal-count pulse, one bit per counter |

## Verification
Two events can land in the same cycle: a chain member stepping from zero, where its roll-over selection applies, and its more significant neighbour reading zero, which forces a base reload. The bench provokes this by loading every member with tiny base counts, so all of them reach zero together. It then sweeps all 64 combinations of chaining and roll-over encodings. A behavioural model computes the count of every register and the state of every pulse each cycle. Each cycle the bench reads back every register and compares it with the model, so a wrong reload choice shows up as a count mismatch one cycle after the coincidence.

// File: rtl/ctm_pkg.sv
// Package: shared constants, address map and control-word layout for the
// cascadable down-counter group. Assumes exactly four counters, since the
// chaining encodings are defined for four.
package ctm_pkg;
    localparam int N_TMR  = 4;
    localparam int CNT_W  = 32;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int PRE_W  = 6;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_BASE0 = 4'd1;
    localparam logic [ADDR_W-1:0] A_CNT0  = 4'd5;
    localparam logic [ADDR_W-1:0] A_INH   = 4'd9;

    // Control word, MSB first: roll-over [8:6], chaining [5:3], rtc mode [2], ratio [1:0]
    typedef struct packed {
        logic [2:0] wrap;
        logic [2:0] chain;
        logic       rtm;
        logic [1:0] ratio;
    } ctm_ctrl_t;

    localparam int CTRL_W = $bits(ctm_ctrl_t);
endpackage

// File: rtl/ctm_regs.sv
// Register file: holds the control word, base counts and inhibit bits,
// decodes writes into per-counter load strobes and a prescaler restart,
// and drives the combinational read mux. Assumes one write per cycle.
module ctm_regs
    import ctm_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    input  logic [N_TMR-1:0][CNT_W-1:0]    cnt,
    output ctm_ctrl_t                      ctrl,
    output logic [N_TMR-1:0][CNT_W-1:0]    base,
    output logic [N_TMR-1:0]               inh,
    output logic [N_TMR-1:0]               ld,
    output logic                           restart,
    output logic [DATA_W-1:0]              rd_data
);
    ctm_ctrl_t ctrl_new;
    logic      wr_ctrl;
    logic      wr_inh;
    logic [N_TMR-1:0] wr_base;

    // Write decode and restart detection on a time-base change
    always_comb begin
        ctrl_new = ctm_ctrl_t'(wr_data[CTRL_W-1:0]);
        wr_ctrl  = wr_en && (wr_addr == A_CTRL);
        wr_inh   = wr_en && (wr_addr == A_INH);
        for (int k = 0; k < N_TMR; k++) begin
            wr_base[k] = wr_en && (wr_addr == A_BASE0 + ADDR_W'(k));
            ld[k]      = wr_base[k] && inh[k];
        end
        restart = wr_ctrl && ({ctrl_new.rtm, ctrl_new.ratio} != {ctrl.rtm, ctrl.ratio});
    end

    // Control word and inhibit storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            inh  <= '1;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_new;
            if (wr_inh)  inh  <= wr_data[N_TMR-1:0];
        end
    end

    // Base count storage, one word per counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
        end else begin
            for (int k = 0; k < N_TMR; k++)
                if (wr_base[k]) base[k] <= wr_data[CNT_W-1:0];
        end
    end

    // Combinational read mux
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL) rd_data = DATA_W'(ctrl);
        if (rd_addr == A_INH)  rd_data = DATA_W'(inh);
        for (int k = 0; k < N_TMR; k++) begin
            if (rd_addr == A_BASE0 + ADDR_W'(k)) rd_data = base[k];
            if (rd_addr == A_CNT0  + ADDR_W'(k)) rd_data = cnt[k];
        end
    end
endmodule

// File: rtl/ctm_prescale.sv
// Time-base generator: a free-running divider of the system clock, or a
// synchronised rising-edge detector on an asynchronous tick. Emits a
// single-cycle tick. Assumes the restart strobe accompanies every change
// of ratio or source, so the divider never sits above its terminal value.
module ctm_prescale
    import ctm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ratio,
    input  logic       rtm,
    input  logic       restart,
    input  logic       rtc_async,
    output logic       tick
);
    logic [PRE_W-1:0] pc;
    logic [PRE_W-1:0] div_m1;
    logic [2:0]       rtc_sync;

    // Terminal value of the divider for the selected ratio
    always_comb begin
        div_m1 = PRE_W'((8 << ratio) - 1);
    end

    // Free-running divider, restarted on a time-base change
    always_ff @(posedge clk) begin
        if (!rst_n || restart)  pc <= '0;
        else if (pc == div_m1)  pc <= '0;
        else                    pc <= pc + PRE_W'(1);
    end

    // Two-stage synchroniser plus an edge-history stage
    always_ff @(posedge clk) begin
        if (!rst_n) rtc_sync <= '0;
        else        rtc_sync <= {rtc_sync[1:0], rtc_async};
    end

    // Tick source selection
    always_comb begin
        tick = rtm ? (rtc_sync[1] & ~rtc_sync[2]) : (pc == div_m1);
    end
endmodule

// File: rtl/ctm_chain.sv
// Chaining decoder: turns the 3-bit chaining code into per-counter feed
// links (bit k set: counter k is fed by counter k-1), chain membership,
// and roll-over eligibility. The top counter never gets roll-over.
module ctm_chain
    import ctm_pkg::*;
(
    input  logic [2:0]       chain,
    input  logic [2:0]       wrap,
    output logic [N_TMR-1:0] link,
    output logic [N_TMR-1:0] member,
    output logic [N_TMR-1:0] wrap_ok
);
    // Feed links per chaining code
    always_comb begin
        unique case (chain)
            3'b000: link = 4'b0000;
            3'b001: link = 4'b0010;
            3'b010: link = 4'b0100;
            3'b011: link = 4'b0110;
            3'b100: link = 4'b1000;
            3'b101: link = 4'b1010;
            3'b110: link = 4'b1100;
            default: link = 4'b1110;
        endcase
    end

    // Membership and roll-over eligibility
    always_comb begin
        for (int k = 0; k < N_TMR; k++) begin
            member[k]  = link[k] | ((k < N_TMR-1) ? link[(k+1) % N_TMR] : 1'b0);
            wrap_ok[k] = (k < N_TMR-1) ? (member[k] & wrap[k % (N_TMR-1)]) : 1'b0;
        end
    end
endmodule

// File: rtl/ctm_counter.sv
// One down-counter: decrements on each step unless inhibited, reloads at a
// step taken from zero (all ones when roll is set, else the base count),
// and registers a one-cycle terminal pulse. An inhibited base write loads
// the count directly.
module ctm_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         inh,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] base,
    input  logic         roll,
    output logic [W-1:0] cnt,
    output logic         tc,
    output logic         pulse
);
    // Terminal event: a live step taken from zero
    always_comb begin
        tc = step & ~inh & (cnt == '0);
    end

    // Count register: load, decrement or reload
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (ld)             cnt <= ld_val;
        else if (step && !inh)   cnt <= (cnt == '0) ? (roll ? '1 : base) : cnt - W'(1);
    end

    // Registered terminal pulse
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= tc;
    end
endmodule

// File: rtl/cascade_timer_group.sv
// Top: four chainable 32-bit down-counters sharing one control word and a
// simple register port. Wires the prescaler, chain decoder and counters;
// each counter's step is either the time-base tick or the terminal event
// of its less significant neighbour.
module cascade_timer_group
    import ctm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rtc_tick_i,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_wr_addr,
    input  logic [DATA_W-1:0] bus_wr_data,
    input  logic [ADDR_W-1:0] bus_rd_addr,
    output logic [DATA_W-1:0] bus_rd_data,
    output logic [N_TMR-1:0]  tc_pulse_o
);
    ctm_ctrl_t                     ctrl;
    logic [N_TMR-1:0][CNT_W-1:0]   base;
    logic [N_TMR-1:0][CNT_W-1:0]   cnt;
    logic [N_TMR-1:0]              inh;
    logic [N_TMR-1:0]              ld;
    logic [N_TMR-1:0]              link;
    logic [N_TMR-1:0]              member;
    logic [N_TMR-1:0]              wrap_ok;
    logic [N_TMR-1:0]              step;
    logic [N_TMR-1:0]              tc;
    logic [N_TMR-1:0]              up_zero;
    logic [N_TMR-1:0]              roll;
    logic                          restart;
    logic                          tick;

    ctm_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr_en),
        .wr_addr (bus_wr_addr),
        .wr_data (bus_wr_data),
        .rd_addr (bus_rd_addr),
        .cnt     (cnt),
        .ctrl    (ctrl),
        .base    (base),
        .inh     (inh),
        .ld      (ld),
        .restart (restart),
        .rd_data (bus_rd_data)
    );

    ctm_prescale u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio     (ctrl.ratio),
        .rtm       (ctrl.rtm),
        .restart   (restart),
        .rtc_async (rtc_tick_i),
        .tick      (tick)
    );

    ctm_chain u_chain (
        .chain   (ctrl.chain),
        .wrap    (ctrl.wrap),
        .link    (link),
        .member  (member),
        .wrap_ok (wrap_ok)
    );

    for (genvar k = 0; k < N_TMR; k++) begin : g_tmr
        if (k == 0) begin : g_step_base
            assign step[k] = tick;
        end else begin : g_step_chain
            assign step[k] = link[k] ? tc[k-1] : tick;
        end

        if (k < N_TMR-1) begin : g_up
            assign up_zero[k] = link[k+1] & (cnt[k+1] == '0);
        end else begin : g_top
            assign up_zero[k] = 1'b0;
        end

        assign roll[k] = wrap_ok[k] & ~up_zero[k];

        ctm_counter #(.W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .step   (step[k]),
            .inh    (inh[k]),
            .ld     (ld[k]),
            .ld_val (bus_wr_data[CNT_W-1:0]),
            .base   (base[k]),
            .roll   (roll[k]),
            .cnt    (cnt[k]),
            .tc     (tc[k]),
            .pulse  (tc_pulse_o[k])
        );
    end
endmodule

// File: rtl/ctm_checker.sv
// Checker bound into the top: temporal properties on ticks, steps, counts
// and pulses of the counter group.
module ctm_checker
    import ctm_pkg::*;
(
    input logic                         clk,
    input logic                         rst_n,
    input logic                         tick,
    input logic [N_TMR-1:0]             step,
    input logic [N_TMR-1:0]             tc,
    input logic [N_TMR-1:0]             inh,
    input logic [N_TMR-1:0]             ld,
    input logic [N_TMR-1:0]             up_zero,
    input logic [N_TMR-1:0][CNT_W-1:0]  cnt,
    input logic [N_TMR-1:0][CNT_W-1:0]  base,
    input logic [N_TMR-1:0]             pulse
);
    // R1 / R2: the time base never ticks in two adjacent cycles
    assert_tick_spaced_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R8: counter 3 reloads with its base count
    assert_top_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tc[N_TMR-1] |=> cnt[N_TMR-1] == $past(base[N_TMR-1]));

    for (genvar k = 0; k < N_TMR; k++) begin : g_chk
        // R5: a live step from a nonzero count decrements by one
        assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (step[k] && !inh[k] && cnt[k] != '0) |=> cnt[k] == $past(cnt[k]) - CNT_W'(1));

        // R10: an inhibited counter keeps its count unless loaded
        assert_inhibit_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (inh[k] && !ld[k]) |=> $stable(cnt[k]));

        // R10: no pulse follows a cycle in which the counter was inhibited
        assert_inhibit_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
            pulse[k] |-> !$past(inh[k]));

        // R12: pulses last exactly one cycle
        assert_pulse_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
            pulse[k] |=> !pulse[k]);

        // R9: upstream at zero forces a base reload
        assert_upzero_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (tc[k] && up_zero[k]) |=> cnt[k] == $past(base[k]));
    end
endmodule

bind cascade_timer_group ctm_checker u_ctm_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .step    (step),
    .tc      (tc),
    .inh     (inh),
    .ld      (ld),
    .up_zero (up_zero),
    .cnt     (cnt),
    .base    (base),
    .pulse   (tc_pulse_o)
);

// File: tb/tb_cascade_timer_group.sv
`timescale 1ns/100ps
// Bench: drives the register port and real-time tick, runs a behavioural
// model of the counter group, and compares every register and pulse each cycle.
module tb_cascade_timer_group;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rtc = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    string tag = "R10";

    always #4 clk = ~clk;

    cascade_timer_group dut (
        .clk(clk), .rst_n(rst_n), .rtc_tick_i(rtc),
        .bus_wr_en(wr_en), .bus_wr_addr(wr_addr), .bus_wr_data(wr_data),
        .bus_rd_addr(rd_addr), .bus_rd_data(rd_data), .tc_pulse_o(pulse)
    );

    // ---------------- behavioural model ----------------
    logic [31:0] m_base [4];
    logic [31:0] m_cnt  [4];
    logic [3:0]  m_inh;
    logic [8:0]  m_ctrl;
    logic [3:0]  m_pulse;
    int          m_pc;
    logic [2:0]  m_rs;

    function automatic logic [3:0] fed_mask(input logic [2:0] c);
        // bit k: counter k steps on counter k-1's zero passage
        case (c)
            3'd0: return 4'b0000;  3'd1: return 4'b0010;
            3'd2: return 4'b0100;  3'd3: return 4'b0110;
            3'd4: return 4'b1000;  3'd5: return 4'b1010;
            3'd6: return 4'b1100;  default: return 4'b1110;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_base[i]) begin m_base[i] = 0; m_cnt[i] = 0; end
            m_inh = 4'hF; m_ctrl = 0; m_pulse = 0; m_pc = 0; m_rs = 0;
        end else begin
            logic [3:0] fm; logic [3:0] tcv; logic tk; int dv;
            logic [31:0] nc [4];
            fm = fed_mask(m_ctrl[5:3]);
            dv = 8 << m_ctrl[1:0];
            tk = m_ctrl[2] ? (m_rs[1] && !m_rs[2]) : (m_pc == dv - 1);
            m_rs = {m_rs[1:0], rtc};
            m_pc = (m_pc == dv - 1) ? 0 : m_pc + 1;
            for (int k = 0; k < 4; k++) begin
                logic st; logic inchain; logic upz;
                st = (k > 0 && fm[k]) ? tcv[k-1] : tk;
                tcv[k] = st && !m_inh[k] && m_cnt[k] == 0;
                nc[k] = m_cnt[k];
                if (st && !m_inh[k]) begin
                    if (m_cnt[k] != 0) nc[k] = m_cnt[k] - 1;
                    else begin
                        inchain = fm[k] || (k < 3 && fm[k+1]);
                        upz = (k < 3) && fm[k+1] && m_cnt[k+1] == 0;
                        nc[k] = (k < 3 && inchain && m_ctrl[6+k] && !upz) ? 32'hFFFF_FFFF : m_base[k];
                    end
                end
            end
            m_pulse = tcv;
            if (wr_en) begin
                if (wr_addr == 0) begin
                    if (wr_data[2:0] != m_ctrl[2:0]) m_pc = 0;
                    m_ctrl = wr_data[8:0];
                end else if (wr_addr == 9) begin
                    m_inh = wr_data[3:0];
                end else if (wr_addr >= 1 && wr_addr <= 4) begin
                    m_base[wr_addr-1] = wr_data;
                    if (m_inh[wr_addr-1]) nc[wr_addr-1] = wr_data;
                end
            end
            for (int k = 0; k < 4; k++) m_cnt[k] = nc[k];
        end
    end

    function automatic logic [31:0] model_rd(input int a);
        if (a == 0) return {23'd0, m_ctrl};
        if (a >= 1 && a <= 4) return m_base[a-1];
        if (a >= 5 && a <= 8) return m_cnt[a-5];
        if (a == 9) return {28'd0, m_inh};
        return 0;
    endfunction

    task automatic chk(input string tg, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h at cycle %0d", tg, got, exp, cyc);
        end
    endtask

    // Per-cycle comparison of every register and the pulses
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int a = 0; a < 10; a++) begin
                rd_addr = 4'(a);
                #0.3;
                chk(tag, rd_data, model_rd(a));
            end
            chk("R12", {28'd0, pulse}, {28'd0, m_pulse});
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            errors++;
            $display("FAIL watchdog expired, got hang expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        tag = "R10";                       // reset state: all inhibited, control zero
        run(3);

        // R1: each ratio on counter 0 alone
        wr(9, 32'hF);
        wr(1, 32'd3);
        for (int r = 0; r < 4; r++) begin
            tag = "R1";
            wr(0, 32'(r));
            wr(9, 32'hE);
            run(300);
        end
        // R3: rewrite same ratio (no restart), then change it mid-phase
        tag = "R3";
        run(5); wr(0, 32'd3); run(37); wr(0, 32'd1); run(21); wr(0, 32'd1); run(50); wr(0, 32'd0); run(60);

        // R2: real-time tick source, ratio bits set but ignored
        tag = "R2";
        wr(0, 32'h7);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            rtc = (i % 5) < 2;
        end
        rtc = 1'b0;

        // R5 / R11: independent counters, base rewrite while running
        tag = "R5";
        wr(9, 32'hF);
        for (int k = 0; k < 4; k++) wr(4'(1 + k), 32'(2 + k));
        wr(0, 32'h0);
        wr(9, 32'h0);
        run(200);
        tag = "R11";
        wr(2, 32'd1);
        run(200);

        // R4 / R6 / R7 / R8 / R9: every chaining code with every roll-over code
        for (int c = 0; c < 8; c++) begin
            for (int w = 0; w < 8; w++) begin
                case ((c * 8 + w) % 5)
                    0: tag = "R4"; 1: tag = "R6"; 2: tag = "R7"; 3: tag = "R8"; default: tag = "R9";
                endcase
                wr(9, 32'hF);
                wr(1, 32'd2); wr(2, 32'd1); wr(3, 32'd1); wr(4, 32'd0);
                wr(0, 32'((w << 6) | (c << 3)));
                wr(9, 32'h0);
                run(250);
            end
        end

        // R10 / R11: inhibit one counter, reload it while inhibited
        tag = "R10";
        wr(0, 32'h0);
        wr(9, 32'h0);
        run(60);
        wr(9, 32'h2);
        run(100);
        tag = "R11";
        wr(2, 32'd7);
        run(4);
        wr(9, 32'h0);
        run(100);

        done = 1'b1;
        run(1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule